// File: doc/BRIEF.md
# Connection CAM with Command Controller

This block is the connection memory of a time-slot switch. It holds three independent content-addressable blocks of 256 locations each. Every location stores a 12-bit comparand, a validity bit and an 8-bit tag. The comparand is a 7-bit time slot in its low bits and a 5-bit stream-plus-control field (stream and direction) in its high bits. A location whose validity bit is clear is free.

Software reaches the block through one write port and two read ports. The write port loads three holding registers (slot, stream-plus-control, tag), a location register and a command word. The read ports are an indirect data word, stepped by read pulses, and a two-bit error word that clears when it is read. A command can store a connection, break one by its comparand, clear a location by its index, read a location back, find a location by its comparand, or reset a block, the holding registers, or everything. A break first searches and then invalidates in the following cycle. During that second cycle the block reports busy and drops any new command.

Top module: `conn_cam`

## Requirements
- R1: After reset every location of all three blocks is invalid, the holding registers, the location register and the read sequence are zero, and `err_data`, `busy` and `idr_data` are 0.
- R2: A write with `wr_sel` 0, 1, 2 or 3 loads the holding slot (bits 6:0), the holding stream-plus-control (bits 4:0), the holding tag (bits 7:0) or the location (bits 7:0). `wr_sel` 4 issues a command with opcode in bits 3:0 and block in bits 5:4. The opcodes are 1 make, 2 break, 3 clear location, 4 read entry, 5 find, 6 reset block, 7 reset holding and 8 reset all. Any other opcode, and block 3 on a block-targeted command, has no effect.
- R3: Make stores the comparand {stream-plus-control, slot} and the tag in the lowest-numbered free location of the block and marks it valid. If the block is full, nothing is stored and error bit 1 (overflow) is set.
- R4: On a hit, break invalidates the matched location one cycle after the command edge. `busy` is 1 for exactly that cycle, and a command issued while `busy` is 1 is ignored.
- R5: A break or find whose comparand matches no valid location sets error bit 0 (underflow) and changes no location.
- R6: Clear location invalidates the location given by the location register, whatever it holds.
- R7: Read entry copies the addressed location into the holding registers and restarts the read sequence. `idr_data` then gives the slot, then {valid, 2'b0, stream-plus-control}, then the tag. Each `idr_rd` pulse steps to the next word, wrapping after the tag. A read entry issued together with a read pulse still starts at the slot.
- R8: Find matches the comparand only, never the tag. On a hit `idr_data` shows the location index until the next read entry.
- R9: When several valid locations match, break and find choose the lowest-numbered one.
- R10: Reset block invalidates all locations of one block. Reset holding clears the three holding registers and the valid copy. Reset all does both for every block.
- R11: Error bits stay set until an `err_rd` pulse clears them. An error raised on the same edge as that pulse survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 8 | Write data |
| idr_rd | input | 1 | Steps the indirect read sequence |
| idr_data | output | 8 | Indirect data word |
| err_rd | input | 1 | Reads and clears the error word |
| err_data | output | 2 | Error word: bit 1 overflow, bit 0 underflow |
| busy | output | 1 | Second cycle of a break in progress |

## Verification
Two pairs of actions can land on the same clock edge. An error-word read can coincide with a command that raises a new error, and a read-entry command can coincide with a read pulse. The bench issues random commands and pulses `err_rd` and `idr_rd` at random, alongside directed cases that put a miss on the same edge as the clearing read. A bench model gives new errors priority over the clear and gives the command's restart priority over the step, and every cycle's error word and indirect word are compared with that model.

// File: rtl/conn_cam.sv
module conn_cam #(
  parameter int BLOCKS = 3,
  parameter int DEPTH  = 256,
  parameter int SLOT_W = 7,
  parameter int STRM_W = 5,
  parameter int TAG_W  = 8,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          idr_rd,
  output logic [DW-1:0] idr_data,
  input  logic          err_rd,
  output logic [1:0]    err_data,
  output logic          busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = SLOT_W + STRM_W;
  localparam int BW = $clog2(BLOCKS);
  localparam logic [BW:0] NBLK = BLOCKS[BW:0];
  localparam logic [3:0] OP_MKC = 4'd1, OP_BKC = 4'd2, OP_CLL = 4'd3, OP_RDC = 4'd4,
                         OP_FEN = 4'd5, OP_RSC = 4'd6, OP_RCH = 4'd7, OP_CI  = 4'd8;

  logic [BLOCKS-1:0][DEPTH-1:0] vld;
  logic [CW-1:0]    cmp_mem [BLOCKS][DEPTH];
  logic [TAG_W-1:0] tag_mem [BLOCKS][DEPTH];

  logic [SLOT_W-1:0] h_slot;
  logic [STRM_W-1:0] h_strm;
  logic [TAG_W-1:0]  h_tag;
  logic              h_v;
  logic [AW-1:0]     loc;
  logic [BW-1:0]     pend_blk;
  logic [AW-1:0]     pend_idx;
  logic [1:0]        err_q;
  logic [1:0]        seq;
  logic              loc_mode;
  logic [AW-1:0]     found_idx;

  wire          cmd_go = wr_en && wr_sel == 3'd4 && !busy;
  wire [3:0]    op     = wr_data[3:0];
  wire [BW-1:0] blk    = wr_data[BW+3:4];
  wire          blk_ok = {1'b0, blk} < NBLK;
  wire [BW-1:0] bi     = blk_ok ? blk : '0;
  wire [CW-1:0] key    = {h_strm, h_slot};

  logic          hit_any, free_any;
  logic [AW-1:0] hit_idx, free_idx;

  always_comb begin
    hit_any  = 1'b0;
    free_any = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld[bi][i] && cmp_mem[bi][i] == key) begin
        hit_any = 1'b1;
        hit_idx = AW'(i);
      end
      if (!vld[bi][i]) begin
        free_any = 1'b1;
        free_idx = AW'(i);
      end
    end
  end

  wire do_store = cmd_go && op == OP_MKC && blk_ok && free_any;
  wire ovf_set  = cmd_go && op == OP_MKC && blk_ok && !free_any;
  wire unf_set  = cmd_go && (op == OP_BKC || op == OP_FEN) && blk_ok && !hit_any;

  always_ff @(posedge clk) begin
    if (do_store) begin
      cmp_mem[bi][free_idx] <= key;
      tag_mem[bi][free_idx] <= h_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= '0;
      h_slot    <= '0;
      h_strm    <= '0;
      h_tag     <= '0;
      h_v       <= 1'b0;
      loc       <= '0;
      busy      <= 1'b0;
      pend_blk  <= '0;
      pend_idx  <= '0;
      err_q     <= '0;
      seq       <= '0;
      loc_mode  <= 1'b0;
      found_idx <= '0;
    end else begin
      err_q <= (err_rd ? 2'b00 : err_q) | {ovf_set, unf_set};
      if (idr_rd && !loc_mode) seq <= (seq == 2'd2) ? 2'd0 : seq + 2'd1;
      if (busy) begin
        vld[pend_blk][pend_idx] <= 1'b0;
        busy <= 1'b0;
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: h_slot <= wr_data[SLOT_W-1:0];
          3'd1: h_strm <= wr_data[STRM_W-1:0];
          3'd2: h_tag  <= wr_data[TAG_W-1:0];
          3'd3: loc    <= wr_data[AW-1:0];
          default: ;
        endcase
      end
      if (cmd_go) begin
        case (op)
          OP_MKC: if (do_store) vld[bi][free_idx] <= 1'b1;
          OP_BKC: if (blk_ok && hit_any) begin
            busy     <= 1'b1;
            pend_blk <= bi;
            pend_idx <= hit_idx;
          end
          OP_CLL: if (blk_ok) vld[bi][loc] <= 1'b0;
          OP_RDC: if (blk_ok) begin
            h_slot   <= cmp_mem[bi][loc][SLOT_W-1:0];
            h_strm   <= cmp_mem[bi][loc][CW-1:SLOT_W];
            h_tag    <= tag_mem[bi][loc];
            h_v      <= vld[bi][loc];
            seq      <= '0;
            loc_mode <= 1'b0;
          end
          OP_FEN: if (blk_ok && hit_any) begin
            found_idx <= hit_idx;
            loc_mode  <= 1'b1;
          end
          OP_RSC: if (blk_ok) vld[bi] <= '0;
          OP_RCH: begin
            h_slot <= '0;
            h_strm <= '0;
            h_tag  <= '0;
            h_v    <= 1'b0;
          end
          OP_CI: begin
            vld    <= '0;
            h_slot <= '0;
            h_strm <= '0;
            h_tag  <= '0;
            h_v    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    idr_data = '0;
    if (loc_mode) idr_data = DW'(found_idx);
    else begin
      case (seq)
        2'd0: idr_data = DW'(h_slot);
        2'd1: begin
          idr_data[STRM_W-1:0] = h_strm;
          idr_data[DW-1]       = h_v;
        end
        default: idr_data = DW'(h_tag);
      endcase
    end
  end

  assign err_data = err_q;

  // R4
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy);
  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_go && op == OP_BKC));
  // R3
  full_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_MKC && blk_ok && !free_any) |=> err_q[1]);
  // R5
  miss_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && (op == OP_FEN || op == OP_BKC) && blk_ok && !hit_any) |=> err_q[0]);
  // R11
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 2'b00 && !err_rd) |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R10
  hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && (op == OP_RCH || op == OP_CI)) |=> (h_slot == '0 && h_strm == '0 && h_tag == '0));
  // R10
  all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_CI) |=> (vld == '0));
endmodule

// File: tb/conn_cam_test.sv
module conn_cam_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       idr_rd = 1'b0;
  logic       err_rd = 1'b0;
  logic [7:0] idr_data;
  logic [1:0] err_data;
  logic       busy;

  always #2 clk = ~clk;

  conn_cam uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .idr_rd(idr_rd), .idr_data(idr_data), .err_rd(err_rd), .err_data(err_data), .busy(busy)
  );

  int n_cmp = 0;
  int n_bad = 0;

  bit         mv [3][256];
  logic [11:0] mc [3][256];
  logic [7:0] mt [3][256];
  logic [6:0] hs = '0;
  logic [4:0] hst = '0;
  logic [7:0] ht = '0;
  bit         hv = 0;
  logic [7:0] mloc = '0;
  bit         mode = 0;
  logic [7:0] fidx = '0;
  int         seq = 0;
  logic [1:0] merr = '0;
  bit         mbusy = 0;
  int         pb = 0, pi = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int find_hit(int b, logic [11:0] k);
    for (int i = 0; i < 256; i++) if (mv[b][i] && mc[b][i] == k) return i;
    return -1;
  endfunction

  function automatic int find_free(int b);
    for (int i = 0; i < 256; i++) if (!mv[b][i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] exp_idr();
    if (mode) return fidx;
    if (seq == 0) return {1'b0, hs};
    if (seq == 1) return {hv, 2'b00, hst};
    return ht;
  endfunction

  task automatic do_cmd(input logic [7:0] d, inout logic [1:0] nerr);
    int op = d[3:0];
    int b = d[5:4];
    bit ok = b < 3;
    logic [11:0] k = {hst, hs};
    int h, f;
    if (!ok && op >= 1 && op <= 6) return;
    case (op)
      1: begin f = find_free(b);
        if (f < 0) nerr[1] = 1'b1;
        else begin mv[b][f] = 1; mc[b][f] = k; mt[b][f] = ht; end
      end
      2: begin h = find_hit(b, k);
        if (h < 0) nerr[0] = 1'b1;
        else begin mbusy = 1; pb = b; pi = h; end
      end
      3: mv[b][mloc] = 0;
      4: begin
        hs = mc[b][mloc][6:0]; hst = mc[b][mloc][11:7]; ht = mt[b][mloc];
        hv = mv[b][mloc]; seq = 0; mode = 0;
      end
      5: begin h = find_hit(b, k);
        if (h < 0) nerr[0] = 1'b1;
        else begin fidx = 8'(h); mode = 1; end
      end
      6: for (int i = 0; i < 256; i++) mv[b][i] = 0;
      7: begin hs = '0; hst = '0; ht = '0; hv = 0; end
      8: begin
        for (int j = 0; j < 3; j++) for (int i = 0; i < 256; i++) mv[j][i] = 0;
        hs = '0; hst = '0; ht = '0; hv = 0;
      end
      default: ;
    endcase
  endtask

  task automatic tick(input string lbl, input bit we, input logic [2:0] sel,
                      input logic [7:0] d, input bit erd, input bit ird);
    logic [1:0] nerr = 2'b00;
    bit was_busy = mbusy;
    wr_en = we; wr_sel = sel; wr_data = d; err_rd = erd; idr_rd = ird;
    if (ird && !mode) seq = (seq == 2) ? 0 : seq + 1;
    if (was_busy) begin mv[pb][pi] = 0; mbusy = 0; end
    if (we) begin
      case (sel)
        3'd0: hs = d[6:0];
        3'd1: hst = d[4:0];
        3'd2: ht = d;
        3'd3: mloc = d;
        3'd4: if (!was_busy) do_cmd(d, nerr);
        default: ;
      endcase
    end
    merr = (erd ? 2'b00 : merr) | nerr;
    @(negedge clk);
    wr_en = 1'b0; err_rd = 1'b0; idr_rd = 1'b0;
    chk({lbl, " R11 err"}, 32'(err_data), 32'(merr));
    chk({lbl, " R4 busy"}, 32'(busy), 32'(mbusy));
    chk({lbl, " R7 idr"}, 32'(idr_data), 32'(exp_idr()));
  endtask

  task automatic cmd(input string lbl, input int op, input int b);
    tick(lbl, 1, 3'd4, {2'b00, 2'(b), 4'(op)}, 0, 0);
  endtask

  task automatic setkey(input string lbl, input logic [6:0] s, input logic [4:0] st);
    tick(lbl, 1, 3'd0, {1'b0, s}, 0, 0);
    tick(lbl, 1, 3'd1, {3'b000, st}, 0, 0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset err", 32'(err_data), 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset idr", 32'(idr_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5: empty block finds nothing after reset
    setkey("R1", 7'd0, 5'd0);
    cmd("R1 R5 find empty", 5, 0);
    tick("R11 clear", 0, 3'd0, 8'd0, 1, 0);

    // R3: fill all blocks, lowest free first
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 256; i++) begin
        setkey("R3 fill", 7'(i), {i[7], 2'(b), 2'b01});
        tick("R3 fill", 1, 3'd2, 8'($urandom_range(0, 255)), 0, 0);
        cmd("R3 fill", 1, b);
      end
    end
    cmd("R3 overflow", 1, 2);
    chk("R3 overflow bit", 32'(err_data), 32'h2);
    tick("R11 read clears", 0, 3'd0, 8'd0, 1, 0);
    chk("R11 cleared", 32'(err_data), 0);

    // R7: read back an entry, three words, wrap
    tick("R7 loc", 1, 3'd3, 8'd200, 0, 0);
    cmd("R7 read", 4, 1);
    chk("R7 slot word", 32'(idr_data), 32'(200 & 8'h7f));
    tick("R7 step", 0, 3'd0, 8'd0, 0, 1);
    chk("R7 stream word", 32'(idr_data), 32'({1'b1, 2'b00, 1'b1, 2'd1, 2'b01}));
    tick("R7 step", 0, 3'd0, 8'd0, 0, 1);
    tick("R7 wrap", 0, 3'd0, 8'd0, 0, 1);
    tick("R7 step", 0, 3'd0, 8'd0, 0, 1);
    // R7: read entry with a simultaneous step restarts at slot
    tick("R7 restart", 1, 3'd4, 8'h14, 0, 1);
    chk("R7 restart slot", 32'(idr_data), 32'(200 & 8'h7f));

    // R4: break with busy; a command during busy is ignored
    setkey("R4", 7'd5, 5'b00101);
    cmd("R4 break", 2, 1);
    chk("R4 busy high", 32'(busy), 1);
    cmd("R4 ignored reset all", 8, 0);
    chk("R4 busy low", 32'(busy), 0);
    cmd("R4 R5 broken gone", 5, 1);
    chk("R5 underflow", 32'(err_data), 32'h1);
    setkey("R4", 7'd6, 5'b00101);
    cmd("R4 neighbour kept", 5, 1);
    chk("R8 index", 32'(idr_data), 6);

    // R11: miss on the same edge as the clearing read
    setkey("R11", 7'd99, 5'd31);
    tick("R11 concurrent", 1, 3'd4, 8'h05, 1, 0);
    chk("R11 set wins", 32'(err_data), 32'h1);
    tick("R11 clear", 0, 3'd0, 8'd0, 1, 0);

    // R9 R8 R6: duplicates, tag ignored, clear location
    cmd("R10 reset all", 8, 0);
    setkey("R9", 7'd3, 5'd2);
    for (int i = 0; i < 3; i++) begin
      tick("R9 tag", 1, 3'd2, 8'(i + 10), 0, 0);
      cmd("R9 dup", 1, 0);
    end
    tick("R8 tag change", 1, 3'd2, 8'hEE, 0, 0);
    cmd("R8 R9 find lowest", 5, 0);
    chk("R9 lowest", 32'(idr_data), 0);
    tick("R6 loc", 1, 3'd3, 8'd0, 0, 0);
    cmd("R6 clear", 3, 0);
    cmd("R9 find next", 5, 0);
    chk("R9 next", 32'(idr_data), 1);
    // R2: block 3 and unused opcode have no effect
    cmd("R2 block3 reset", 6, 3);
    cmd("R2 opcode 12", 12, 0);
    cmd("R2 still found", 5, 0);
    chk("R2 intact", 32'(idr_data), 1);
    // R10: reset block and reset holding
    cmd("R10 reset block", 6, 0);
    cmd("R10 find after", 5, 0);
    cmd("R10 reset holding", 7, 0);
    cmd("R7 read", 4, 0);
    tick("R11 clear", 0, 3'd0, 8'd0, 1, 0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int pick = $urandom_range(0, 9);
      bit erd = ($urandom_range(0, 3) == 0);
      bit ird = ($urandom_range(0, 2) == 0);
      if (pick == 0) tick("R2 rnd slot", 1, 3'd0, 8'($urandom_range(0, 3)), erd, ird);
      else if (pick == 1) tick("R2 rnd strm", 1, 3'd1, 8'($urandom_range(0, 1)), erd, ird);
      else if (pick == 2) tick("R8 rnd tag", 1, 3'd2, 8'($urandom_range(0, 255)), erd, ird);
      else if (pick == 3) tick("R6 rnd loc", 1, 3'd3, 8'($urandom_range(0, 15)), erd, ird);
      else if (pick == 4) tick("R7 rnd idle", 0, 3'd0, 8'd0, erd, ird);
      else begin
        int op = $urandom_range(0, 99);
        int o;
        if (op < 30) o = 1; else if (op < 45) o = 2; else if (op < 55) o = 3;
        else if (op < 68) o = 4; else if (op < 84) o = 5; else if (op < 90) o = 6;
        else if (op < 95) o = 7; else if (op < 98) o = 8; else o = 0;
        tick("R3 R4 R5 R9 R10 rnd cmd", 1, 3'd4,
             {2'b00, 2'($urandom_range(0, 3)), 4'(o)}, erd, ird);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule